// File: doc/BRIEF.md
# CRTC bitmap pixel serializer

This block sits between a CRT controller and a pair of byte-wide video memories. For each character slot the controller presents a memory address count and a raster row count, and a one-cycle load strobe marks them. The block interleaves the two counts into a 13-bit memory address and inverts that address when the screen is flipped. It fetches one bitmap byte and one attribute byte from the shared address, then plays the bitmap out one pixel per pixel clock.

The bitmap is one bit per pixel. A lit pixel takes the 3-bit foreground colour held in the top three bits of the attribute byte. A dark pixel, and every pixel of a character fetched while display-enable was low, is black. The flip control is active low. A flipped screen reads the mirrored address and plays each byte out starting from its opposite end, so the picture turns through 180 degrees. Both memories have a registered read port with one cycle of latency. The pixel clock runs eight times the character rate, so load strobes arrive at least eight pixel clocks apart.

Top module: `crtc_pix_serializer`

## Requirements
- R1: The address is {ma_i[9:5], ra_i[2:0], ma_i[4:0]}, from most to least significant bit. Bits ma_i[13:10] and ra_i[4:3] have no effect on it.
- R2: When flip_ctl_i is 0 at the load strobe, the address is inverted in every bit (XOR 0x1FFF). When flip_ctl_i is 1, the address is used as formed.
- R3: In normal mode (flip_ctl_i = 1) the eight pixels of a byte leave in order bit 7, bit 6, ..., bit 0.
- R4: In flipped mode (flip_ctl_i = 0) the eight pixels leave in order bit 0, bit 1, ..., bit 7.
- R5: A pixel bit of 1 outputs attribute bits 7:5 from the same address, and a bit of 0 outputs 3'b000. On rgb_o, bit 2 is red, bit 1 is green and bit 0 is blue.
- R6: When de_i is 0 at the load strobe, all eight pixels of that character output 3'b000, while pix_vld_o stays high.
- R7: vram_rd_o is high, and vram_addr_o carries the character's address, in exactly the cycle after char_ld_i. vram_addr_o does not change in any other cycle. The first pixel appears 9 cycles after the char_ld_i cycle, and the other seven follow in consecutive cycles.
- R8: pix_vld_o is high for exactly the 8 pixel cycles of each loaded character and low otherwise. While pix_vld_o is low, rgb_o is 3'b000.
- R9: During and just after reset, rgb_o, pix_vld_o, vram_rd_o and vram_addr_o are all zero.
- R10: Flip and display-enable are sampled per character at its load strobe, so adjacent characters may use different modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_ld_i | input | 1 | One-cycle strobe: ma_i, ra_i, de_i and flip_ctl_i are valid |
| ma_i | input | 14 | Controller memory address count |
| ra_i | input | 5 | Controller raster row count |
| de_i | input | 1 | Controller display enable |
| flip_ctl_i | input | 1 | Screen flip control, active low |
| vram_addr_o | output | 13 | Shared address to the bitmap and attribute memories |
| vram_rd_o | output | 1 | Read strobe for both memories |
| vram_rdata_i | input | 8 | Bitmap byte, one cycle after the read |
| cram_rdata_i | input | 8 | Attribute byte, one cycle after the read |
| rgb_o | output | 3 | Pixel colour {red, green, blue} |
| pix_vld_o | output | 1 | High on each pixel cycle of a loaded character |

## Verification
The bench goes after the places where the block can get the image wrong without going silent:
- Address values at the edges of the space: all ones, all zeros, and the count bits that must be ignored. A wrong bit interleave or a partial inversion would fetch the neighbouring row or a mirrored column.
- Bitmap bytes of all zeros and all ones. A reversed shift direction in one mode would mirror each 8-pixel cell.
- Characters that mix flip and blanking from one character to the next. Using the wrong character's mode would smear the previous setting across a boundary.
- Load strobes spaced wider than eight cycles. A serializer that drops pixel-valid late, or reloads stale data, would show up as extra or missing pixels in the gaps.

// File: rtl/crtc_pix_pkg.sv
package crtc_pix_pkg;
  parameter int PIX_W  = 8;  // pixels per fetched byte
  parameter int COL_W  = 3;  // colour code bits
  parameter int CRAM_W = 8;  // attribute byte width
  localparam int COL_LSB = CRAM_W - COL_W;
  localparam logic [COL_W-1:0] BLACK = '0;

  typedef struct packed {
    logic [PIX_W-1:0] bits;
    logic [COL_W-1:0] col;
    logic             flip;
    logic             de;
  } char_word_t;
endpackage

// File: rtl/crtc_pix_addr_map.sv
module crtc_pix_addr_map #(
  parameter int MA_W     = 14,
  parameter int RA_W     = 5,
  parameter int MA_LO_W  = 5,
  parameter int MA_HI_W  = 5,
  parameter int RA_USE_W = 3,
  parameter int ADDR_W   = MA_LO_W + RA_USE_W + MA_HI_W
) (
  input  logic [MA_W-1:0]   ma_i,
  input  logic [RA_W-1:0]   ra_i,
  input  logic              flip_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int RA_BASE = MA_LO_W;
  localparam int HI_BASE = MA_LO_W + RA_USE_W;

  logic [ADDR_W-1:0] raw;
  logic              unused_bits;

  genvar gi;
  generate
    for (gi = 0; gi < MA_LO_W; gi++) begin : g_lo
      assign raw[gi] = ma_i[gi];
    end
    for (gi = 0; gi < RA_USE_W; gi++) begin : g_row
      assign raw[RA_BASE+gi] = ra_i[gi];
    end
    for (gi = 0; gi < MA_HI_W; gi++) begin : g_hi
      assign raw[HI_BASE+gi] = ma_i[MA_LO_W+gi];
    end
  endgenerate

  // flipped screen reads the point-mirrored cell
  assign addr_o      = raw ^ {ADDR_W{flip_i}};
  assign unused_bits = ^{ma_i[MA_W-1:MA_LO_W+MA_HI_W], ra_i[RA_W-1:RA_USE_W]};
endmodule

// File: rtl/crtc_pix_fetch.sv
module crtc_pix_fetch
  import crtc_pix_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_ld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              flip_i,
  input  logic              de_i,
  output logic [ADDR_W-1:0] vram_addr_o,
  output logic              vram_rd_o,
  input  logic [PIX_W-1:0]  vram_rdata_i,
  input  logic [CRAM_W-1:0] cram_rdata_i,
  input  logic              take_i,
  output char_word_t        word_o,
  output logic              word_vld_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q, flip_a, de_a;
  logic              vld_b, flip_b, de_b;
  char_word_t        word_q;
  logic              pend_q;
  logic              unused_attr;

  // stage A: address to memories
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rd_q   <= 1'b0;
      flip_a <= 1'b0;
      de_a   <= 1'b0;
    end else begin
      rd_q <= char_ld_i;
      if (char_ld_i) begin
        addr_q <= addr_i;
        flip_a <= flip_i;
        de_a   <= de_i;
      end
    end
  end

  // stage B: memory read in flight
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_b  <= 1'b0;
      flip_b <= 1'b0;
      de_b   <= 1'b0;
    end else begin
      vld_b  <= rd_q;
      flip_b <= flip_a;
      de_b   <= de_a;
    end
  end

  // stage C: hold word until the shifter takes it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      pend_q <= 1'b0;
    end else if (vld_b) begin
      word_q.bits <= vram_rdata_i;
      word_q.col  <= cram_rdata_i[CRAM_W-1:COL_LSB];
      word_q.flip <= flip_b;
      word_q.de   <= de_b;
      pend_q      <= 1'b1;
    end else if (take_i) begin
      pend_q <= 1'b0;
    end
  end

  assign vram_addr_o = addr_q;
  assign vram_rd_o   = rd_q;
  assign word_o      = word_q;
  assign word_vld_o  = pend_q;
  assign unused_attr = ^cram_rdata_i[COL_LSB-1:0];
endmodule

// File: rtl/crtc_pix_shifter.sv
module crtc_pix_shifter
  import crtc_pix_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             char_ld_i,
  input  char_word_t       word_i,
  input  logic             word_vld_i,
  output logic             take_o,
  output logic [COL_W-1:0] rgb_o,
  output logic             pix_vld_o
);
  localparam int PH_W  = (PIX_W > 1) ? $clog2(PIX_W) : 1;
  localparam int CNT_W = $clog2(PIX_W + 1);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(PIX_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PIX_W);

  logic [PH_W-1:0]  phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PIX_W-1:0] sh_q;
  logic             flip_q;
  logic [COL_W-1:0] col_q;
  logic             pix_bit;

  assign take_o = (phase_q == PH_LAST);

  // pixel phase, realigned by every load strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  phase_q <= '0;
    else if (char_ld_i || take_o) phase_q <= '0;
    else                          phase_q <= phase_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      flip_q <= 1'b0;
      col_q  <= BLACK;
      cnt_q  <= '0;
    end else if (take_o) begin
      sh_q   <= word_i.bits;
      flip_q <= word_i.flip;
      col_q  <= word_i.de ? word_i.col : BLACK;
      cnt_q  <= word_vld_i ? CNT_FULL : '0;
    end else if (cnt_q != '0) begin
      sh_q  <= flip_q ? (sh_q >> 1) : (sh_q << 1);
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign pix_bit   = flip_q ? sh_q[0] : sh_q[PIX_W-1];
  assign pix_vld_o = (cnt_q != '0);
  assign rgb_o     = (pix_vld_o && pix_bit) ? col_q : BLACK;
endmodule

// File: rtl/crtc_pix_serializer.sv
module crtc_pix_serializer
  import crtc_pix_pkg::*;
#(
  parameter int MA_W     = 14,
  parameter int RA_W     = 5,
  parameter int MA_LO_W  = 5,
  parameter int MA_HI_W  = 5,
  parameter int RA_USE_W = 3,
  localparam int ADDR_W  = MA_LO_W + RA_USE_W + MA_HI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_ld_i,
  input  logic [MA_W-1:0]   ma_i,
  input  logic [RA_W-1:0]   ra_i,
  input  logic              de_i,
  input  logic              flip_ctl_i,
  output logic [ADDR_W-1:0] vram_addr_o,
  output logic              vram_rd_o,
  input  logic [PIX_W-1:0]  vram_rdata_i,
  input  logic [CRAM_W-1:0] cram_rdata_i,
  output logic [COL_W-1:0]  rgb_o,
  output logic              pix_vld_o
);
  logic              flip;
  logic [ADDR_W-1:0] addr_c;
  char_word_t        word;
  logic              word_vld, take;

  assign flip = ~flip_ctl_i;

  crtc_pix_addr_map #(
    .MA_W(MA_W), .RA_W(RA_W), .MA_LO_W(MA_LO_W), .MA_HI_W(MA_HI_W),
    .RA_USE_W(RA_USE_W), .ADDR_W(ADDR_W)
  ) addr_map_i (
    .ma_i  (ma_i),
    .ra_i  (ra_i),
    .flip_i(flip),
    .addr_o(addr_c)
  );

  crtc_pix_fetch #(.ADDR_W(ADDR_W)) fetch_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .char_ld_i   (char_ld_i),
    .addr_i      (addr_c),
    .flip_i      (flip),
    .de_i        (de_i),
    .vram_addr_o (vram_addr_o),
    .vram_rd_o   (vram_rd_o),
    .vram_rdata_i(vram_rdata_i),
    .cram_rdata_i(cram_rdata_i),
    .take_i      (take),
    .word_o      (word),
    .word_vld_o  (word_vld)
  );

  crtc_pix_shifter shifter_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .char_ld_i (char_ld_i),
    .word_i    (word),
    .word_vld_i(word_vld),
    .take_o    (take),
    .rgb_o     (rgb_o),
    .pix_vld_o (pix_vld_o)
  );
endmodule

// File: rtl/crtc_pix_serializer_chk.sv
module crtc_pix_serializer_chk
  import crtc_pix_pkg::*;
#(
  parameter int MA_W     = 14,
  parameter int RA_W     = 5,
  parameter int MA_LO_W  = 5,
  parameter int MA_HI_W  = 5,
  parameter int RA_USE_W = 3,
  parameter int ADDR_W   = MA_LO_W + RA_USE_W + MA_HI_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              char_ld_i,
  input logic [MA_W-1:0]   ma_i,
  input logic [RA_W-1:0]   ra_i,
  input logic              flip_ctl_i,
  input logic [ADDR_W-1:0] vram_addr_o,
  input logic              vram_rd_o,
  input logic [COL_W-1:0]  rgb_o,
  input logic              pix_vld_o
);
  logic unused_chk;
  assign unused_chk = ^{ma_i[MA_W-1:MA_LO_W+MA_HI_W], ra_i[RA_W-1:RA_USE_W]};

  // R7
  rd_after_ld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_ld_i |=> vram_rd_o);

  // R7
  rd_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vram_rd_o |-> $past(char_ld_i));

  // R7
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !char_ld_i |=> $stable(vram_addr_o));

  // R1 R2
  addr_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_ld_i |=> (vram_addr_o ==
      ({$past(ma_i[MA_LO_W+MA_HI_W-1:MA_LO_W]), $past(ra_i[RA_USE_W-1:0]),
        $past(ma_i[MA_LO_W-1:0])} ^ {ADDR_W{~$past(flip_ctl_i)}})));

  // R8
  idle_black_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_vld_o |-> (rgb_o == BLACK));
endmodule

bind crtc_pix_serializer crtc_pix_serializer_chk #(
  .MA_W(MA_W), .RA_W(RA_W), .MA_LO_W(MA_LO_W), .MA_HI_W(MA_HI_W),
  .RA_USE_W(RA_USE_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .char_ld_i  (char_ld_i),
  .ma_i       (ma_i),
  .ra_i       (ra_i),
  .flip_ctl_i (flip_ctl_i),
  .vram_addr_o(vram_addr_o),
  .vram_rd_o  (vram_rd_o),
  .rgb_o      (rgb_o),
  .pix_vld_o  (pix_vld_o)
);

// File: tb/crtc_pix_serializer_tb_top.sv
module crtc_pix_serializer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        char_ld_i = 1'b0;
  logic [13:0] ma_i = '0;
  logic [4:0]  ra_i = '0;
  logic        de_i = 1'b0;
  logic        flip_ctl_i = 1'b1;
  logic [12:0] vram_addr_o;
  logic        vram_rd_o;
  logic [7:0]  vram_rdata_i = '0;
  logic [7:0]  cram_rdata_i = '0;
  logic [2:0]  rgb_o;
  logic        pix_vld_o;

  always #4 clk_i = ~clk_i;

  crtc_pix_serializer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .char_ld_i(char_ld_i), .ma_i(ma_i),
    .ra_i(ra_i), .de_i(de_i), .flip_ctl_i(flip_ctl_i),
    .vram_addr_o(vram_addr_o), .vram_rd_o(vram_rd_o),
    .vram_rdata_i(vram_rdata_i), .cram_rdata_i(cram_rdata_i),
    .rgb_o(rgb_o), .pix_vld_o(pix_vld_o)
  );

  typedef struct packed {
    int          t;
    logic [13:0] ma;
    logic [4:0]  ra;
    logic        de;
    logic        fc;
    logic [3:0]  tag;
  } ch_t;

  ch_t q[$];
  int  cyc = 0;
  int  n_chk = 0;
  int  n_err = 0;
  bit  mon_en = 1'b0;
  bit  done = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [12:0] xaddr(logic [13:0] ma, logic [4:0] ra, logic fc);
    logic [12:0] a;
    a = {ma[9:5], ra[2:0], ma[4:0]};
    return fc ? a : (a ^ 13'h1fff);
  endfunction

  function automatic logic [7:0] vf(logic [12:0] a);
    int x;
    x = int'(a);
    if (a[4:0] == 5'h1f) return 8'hff;
    if (a[4:0] == 5'h00) return 8'h00;
    return 8'((x * 37) ^ (x >> 5) ^ 8'h5a);
  endfunction

  function automatic logic [7:0] cf(logic [12:0] a);
    int x;
    x = int'(a);
    return 8'((x * 13) ^ (x >> 3) ^ 8'ha5);
  endfunction

  function automatic string tagname(logic [3:0] t);
    case (t)
      4'd0:    return "R3 R5";
      4'd1:    return "R2 R4";
      4'd2:    return "R6";
      4'd3:    return "R1";
      4'd4:    return "R10";
      default: return "R8";
    endcase
  endfunction

  // memory model: registered read, one cycle latency
  always @(posedge clk_i) begin
    vram_rdata_i <= vf(vram_addr_o);
    cram_rdata_i <= cf(vram_addr_o);
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk_i) begin
    bit in_pix;
    bit in_addr;
    in_pix  = 1'b0;
    in_addr = 1'b0;
    if (mon_en) begin
      for (int k = 0; k < q.size(); k++) begin
        int d;
        d = cyc - q[k].t;
        if (d == 1) begin
          logic [12:0] ea;
          in_addr = 1'b1;
          ea = xaddr(q[k].ma, q[k].ra, q[k].fc);
          chk(vram_rd_o && vram_addr_o == ea, {"R7 ", tagname(q[k].tag)}, "read address",
              int'({vram_rd_o, vram_addr_o}), int'({1'b1, ea}));
        end
        if (d >= 9 && d <= 16) begin
          int          i;
          logic [12:0] a;
          logic [7:0]  v;
          logic        b;
          logic [2:0]  e;
          in_pix = 1'b1;
          i = d - 9;
          a = xaddr(q[k].ma, q[k].ra, q[k].fc);
          v = vf(a);
          b = q[k].fc ? v[7-i] : v[i];
          e = (q[k].de && b) ? cf(a)[7:5] : 3'b000;
          chk(pix_vld_o && rgb_o == e, tagname(q[k].tag), "pixel {vld,rgb}",
              int'({pix_vld_o, rgb_o}), int'({1'b1, e}));
        end
      end
      if (!in_addr) chk(!vram_rd_o, "R7", "idle read strobe", int'(vram_rd_o), 0);
      if (!in_pix)  chk(!pix_vld_o && rgb_o == 3'b000, "R8", "idle {vld,rgb}",
                        int'({pix_vld_o, rgb_o}), 0);
      while (q.size() > 0 && cyc - q[0].t >= 16) void'(q.pop_front());
    end
  end

  task automatic send(input logic [13:0] ma, input logic [4:0] ra, input logic de,
                      input logic fc, input logic [3:0] tag, input int gap);
    ch_t c;
    @(negedge clk_i);
    char_ld_i  = 1'b1;
    ma_i       = ma;
    ra_i       = ra;
    de_i       = de;
    flip_ctl_i = fc;
    c.t = cyc; c.ma = ma; c.ra = ra; c.de = de; c.fc = fc; c.tag = tag;
    q.push_back(c);
    @(negedge clk_i);
    char_ld_i = 1'b0;
    ma_i      = ~ma;
    ra_i      = ~ra;
    de_i      = ~de;
    repeat (gap - 2) @(negedge clk_i);
  endtask

  task automatic drain(input string tag);
    repeat (24) @(negedge clk_i);
    chk(q.size() == 0, tag, "all characters drained", q.size(), 0);
  endtask

  task automatic test_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(rgb_o == 0 && !pix_vld_o && !vram_rd_o && vram_addr_o == 0, "R9", "in reset",
        int'({rgb_o, pix_vld_o, vram_rd_o, vram_addr_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(rgb_o == 0 && !pix_vld_o && !vram_rd_o && vram_addr_o == 0, "R9", "after reset",
        int'({rgb_o, pix_vld_o, vram_rd_o, vram_addr_o}), 0);
    mon_en = 1'b1;
  endtask

  task automatic test_normal();
    for (int k = 0; k < 6; k++)
      send(14'((k * 37 + 3) & 10'h3ff), 5'(k), 1'b1, 1'b1, 4'd0, 8);
    drain("R3");
  endtask

  task automatic test_flip();
    for (int k = 0; k < 6; k++)
      send(14'((k * 53 + 9) & 10'h3ff), 5'(k + 2), 1'b1, 1'b0, 4'd1, 8);
    drain("R4");
  endtask

  task automatic test_blank();
    send(14'h012, 5'd1, 1'b1, 1'b1, 4'd2, 8);
    send(14'h013, 5'd1, 1'b0, 1'b1, 4'd2, 8);
    send(14'h0ff, 5'd3, 1'b0, 1'b0, 4'd2, 8);
    send(14'h100, 5'd4, 1'b1, 1'b1, 4'd2, 8);
    send(14'h1f0, 5'd6, 1'b0, 1'b1, 4'd2, 8);
    drain("R6");
  endtask

  task automatic test_boundary();
    send(14'h3fff, 5'h1f, 1'b1, 1'b1, 4'd3, 8);  // addr 1fff, byte ff
    send(14'h3c00, 5'h18, 1'b1, 1'b1, 4'd3, 8);  // addr 0000, byte 00
    send(14'h0000, 5'h00, 1'b1, 1'b0, 4'd3, 8);  // flipped -> 1fff
    send(14'h03ff, 5'h07, 1'b1, 1'b0, 4'd3, 8);  // flipped -> 0000
    send(14'h2c35, 5'h1a, 1'b1, 1'b1, 4'd3, 8);  // high bits ignored
    drain("R1");
  endtask

  task automatic test_mixed();
    for (int k = 0; k < 6; k++)
      send(14'(k * 71 + 5), 5'(k * 3), 1'(k % 3 != 2), 1'(k % 2), 4'd4, 8);
    drain("R10");
  endtask

  task automatic test_gap();
    send(14'h055, 5'd2, 1'b1, 1'b1, 4'd5, 11);
    send(14'h0aa, 5'd5, 1'b1, 1'b0, 4'd5, 20);
    send(14'h123, 5'd7, 1'b1, 1'b1, 4'd5, 8);
    send(14'h321, 5'd0, 1'b1, 1'b1, 4'd5, 9);
    drain("R8");
  endtask

  initial begin
    test_reset();
    test_normal();
    test_flip();
    test_blank();
    test_boundary();
    test_mixed();
    test_gap();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  always @(posedge clk_i) begin
    if (!done && cyc > 20000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule